// File: doc/BRIEF.md
# Instruction packet splitter

This block sits between instruction fetch and the issue stage of a wide parallel-issue core. Fetch delivers one 128-bit word per cycle. That word holds one or more instruction packets, and a packet may run past the end of the word into the next one. The splitter breaks each packet into its separate instructions. Instructions are 16, 32 or 48 bits long, a packet holds at most eight of them, and a packet never exceeds 128 bits. All instructions of a packet are presented together on up to eight output slots, so that they issue in the same cycle.

The length of each instruction is read from a code in the low bits of its first halfword. A flag bit in that halfword marks the last instruction of the packet. Halfwords left over after a packet ends stay in a carry buffer. The next fetch word is appended behind them, so a packet that straddles two fetch words issues once its last halfword has arrived. With each packet the block also reports its length in bytes, which is what the fetch pointer advances by.

A packet with a malformed length, or one that would grow past 128 bits, produces an illegal-packet indication instead of issuing. The downstream stage paces the block with a ready signal.

Top module: `vliw_pkt_splitter`

## Requirements
- R1: Bits [1:0] of an instruction's first halfword give its length: 00 is one halfword, 01 is two, 10 is three. The slot length output gives that count (1, 2 or 3). The slot instruction field holds the first halfword in bits [15:0] and each following halfword in the next 16 bits up, with the unused upper bits at zero.
- R2: Bit 2 of the first halfword, when set, marks the last instruction of the packet. The instructions of a packet fill slots from slot 0 upward in stream order, and `pkt_bytes` is twice the packet's halfword count.
- R3: A length code of 11 produces one output cycle with `pkt_illegal` = 1, `pkt_valid` = 0 and no slot valid. Every halfword held in the carry buffer at that point is discarded.
- R4: If a packet has no end flag within its first eight halfwords, or an instruction would extend past halfword eight of the packet, the block treats it as illegal in the same way as R3.
- R5: Halfwords after a packet's end stay buffered ahead of the next fetch word. A packet whose halfwords are not all present yet is not issued, and it issues once the remaining halfwords arrive.
- R6: `fetch_ready` is 1 exactly when at most eight halfwords are buffered. A word is taken on a clock edge where `fetch_valid` and `fetch_ready` are both 1. Halfword 0 of a fetch word is bits [15:0] and comes first in the stream.
- R7: On a clock edge where `out_ready` is 0, every output holds its value and no buffered halfword is consumed.
- R8: Slots not used by the current packet show valid 0, length 0 and instruction bits 0. When no complete packet is available on an edge where `out_ready` is 1, `pkt_valid` drops to 0.
- R9: After reset the buffer is empty, `fetch_ready` is 1 and all packet and slot outputs are 0.
- R10: A packet that is complete in the buffer after clock edge k appears on the outputs after the next edge at which `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid | input | 1 | A fetch word is offered |
| fetch_word | input | 128 | Fetched word, halfword 0 in bits [15:0] |
| fetch_ready | output | 1 | The buffer can take a fetch word |
| out_ready | input | 1 | Downstream takes the current packet and lets the next one load |
| pkt_valid | output | 1 | The slots hold a complete packet |
| pkt_illegal | output | 1 | The last packet was malformed and was dropped |
| pkt_bytes | output | 5 | Byte length of the packet shown |
| slot_valid | output | 8 | Per-slot valid, slot 0 in bit 0 |
| slot_len | output | 16 | Per-slot halfword count, 2 bits per slot |
| slot_insn | output | 384 | Per-slot instruction, 48 bits per slot, slot 0 lowest |

## Verification
The main stream is a table of packets with mixed lengths: a lone 16-bit instruction, a lone 48-bit instruction, eight 16-bit instructions, and packets of exactly 128 bits built from 32-bit and 48-bit instructions. The packets are laid end to end, so many of them straddle fetch-word boundaries, and the downstream ready signal is taken away at regular intervals. The stream shows whether the length decoding, the slot ordering and the carry across words are correct, and whether the outputs hold while stalled. Directed cases then separate the three illegal forms (a reserved code, a missing end flag, and an instruction that crosses the 128-bit limit). Further cases cover a packet that waits for the second word, and back-pressure that fills the buffer until `fetch_ready` drops.

// File: rtl/pks_pkg.sv
package pks_pkg;
  // Position of the last-in-packet flag in an instruction's first halfword.
  localparam int END_BIT = 2;
  localparam logic [1:0] CODE_RESERVED = 2'b11;

  // Halfwords taken by an instruction of length code c; 0 marks a reserved code.
  function automatic int code_halfwords(input logic [1:0] c);
    if (c == CODE_RESERVED) return 0;
    return int'(c) + 1;
  endfunction

  function automatic int halfwords_to_bytes(input int n);
    return 2 * n;
  endfunction
endpackage

// File: rtl/pks_carry_buf.sv
module pks_carry_buf import pks_pkg::*; #(
  parameter int HW_W   = 16,
  parameter int PKT_HW = 8,
  parameter int BUF_HW = 2 * PKT_HW,
  parameter int CNT_W  = $clog2(BUF_HW + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              push_i,
  input  logic [PKT_HW-1:0][HW_W-1:0]       word_i,
  input  logic [CNT_W-1:0]                  pop_i,
  output logic [BUF_HW-1:0][HW_W-1:0]       hw_o,
  output logic [CNT_W-1:0]                  cnt_o,
  output logic                              room_o
);
  logic [BUF_HW-1:0][HW_W-1:0] hw_q, hw_d;
  logic [CNT_W-1:0]            cnt_q, cnt_d, rem;

  always_comb begin
    rem  = cnt_q - pop_i;
    hw_d = '0;
    for (int i = 0; i < BUF_HW; i++) begin
      if (i + int'(pop_i) < BUF_HW) hw_d[i] = hw_q[i + int'(pop_i)];
    end
    if (push_i) begin
      for (int j = 0; j < PKT_HW; j++) hw_d[int'(rem) + j] = word_i[j];
    end
    cnt_d = rem + (push_i ? CNT_W'(PKT_HW) : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hw_q  <= '0;
      cnt_q <= '0;
    end else begin
      hw_q  <= hw_d;
      cnt_q <= cnt_d;
    end
  end

  assign hw_o   = hw_q;
  assign cnt_o  = cnt_q;
  assign room_o = (cnt_q <= CNT_W'(PKT_HW));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BUF_HW)); // R6
  AST_POP_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i <= cnt_q); // R5
endmodule

// File: rtl/pks_parse.sv
module pks_parse import pks_pkg::*; #(
  parameter int HW_W   = 16,
  parameter int PKT_HW = 8,
  parameter int NSLOT  = 8,
  parameter int INS_HW = 3,
  parameter int BUF_HW = 2 * PKT_HW,
  parameter int CNT_W  = $clog2(BUF_HW + 1),
  localparam int INS_W = INS_HW * HW_W
) (
  input  logic [BUF_HW-1:0][HW_W-1:0] hw_i,
  input  logic [CNT_W-1:0]            cnt_i,
  output logic                        done_o,
  output logic                        bad_o,
  output logic [CNT_W-1:0]            used_o,
  output logic [NSLOT-1:0]            vld_o,
  output logic [NSLOT-1:0][1:0]       len_o,
  output logic [NSLOT-1:0][INS_W-1:0] ins_o
);
  always_comb begin
    int pos;
    int n;
    logic stop;
    pos    = 0;
    n      = 0;
    stop   = 1'b0;
    done_o = 1'b0;
    bad_o  = 1'b0;
    vld_o  = '0;
    len_o  = '0;
    ins_o  = '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (!stop) begin
        if (pos >= PKT_HW) begin
          bad_o = 1'b1;                       // no end flag within the limit
          stop  = 1'b1;
        end else if (pos >= int'(cnt_i)) begin
          stop = 1'b1;                        // next halfword not fetched yet
        end else begin
          n = code_halfwords(hw_i[pos][1:0]);
          if (n == 0 || pos + n > PKT_HW) begin
            bad_o = 1'b1;                     // reserved code or crosses limit
            stop  = 1'b1;
          end else if (pos + n > int'(cnt_i)) begin
            stop = 1'b1;                      // tail of instruction missing
          end else begin
            vld_o[s] = 1'b1;
            len_o[s] = 2'(n);
            for (int k = 0; k < INS_HW; k++) begin
              if (k < n) ins_o[s][k*HW_W +: HW_W] = hw_i[pos + k];
            end
            if (hw_i[pos][END_BIT]) begin
              done_o = 1'b1;
              stop   = 1'b1;
            end
            pos = pos + n;
          end
        end
      end
    end
    if (!stop) bad_o = 1'b1;                  // every slot used, still no end
    used_o = done_o ? CNT_W'(pos) : (bad_o ? cnt_i : '0);
  end
endmodule

// File: rtl/pks_issue_reg.sv
module pks_issue_reg import pks_pkg::*; #(
  parameter int HW_W   = 16,
  parameter int PKT_HW = 8,
  parameter int NSLOT  = 8,
  parameter int INS_HW = 3,
  parameter int CNT_W  = $clog2(2 * PKT_HW + 1),
  localparam int INS_W  = INS_HW * HW_W,
  localparam int BYTE_W = $clog2(2 * PKT_HW + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        adv_i,
  input  logic                        done_i,
  input  logic                        bad_i,
  input  logic [CNT_W-1:0]            used_i,
  input  logic [NSLOT-1:0]            vld_i,
  input  logic [NSLOT-1:0][1:0]       len_i,
  input  logic [NSLOT-1:0][INS_W-1:0] ins_i,
  output logic                        pkt_vld_o,
  output logic                        pkt_ill_o,
  output logic [BYTE_W-1:0]           bytes_o,
  output logic [NSLOT-1:0]            vld_o,
  output logic [NSLOT-1:0][1:0]       len_o,
  output logic [NSLOT-1:0][INS_W-1:0] ins_o
);
  logic              vld_q, ill_q;
  logic [BYTE_W-1:0] bytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      ill_q   <= 1'b0;
      bytes_q <= '0;
    end else if (adv_i) begin
      vld_q   <= done_i;
      ill_q   <= bad_i;
      bytes_q <= done_i ? BYTE_W'(halfwords_to_bytes(int'(used_i))) : '0;
    end
  end

  assign pkt_vld_o = vld_q;
  assign pkt_ill_o = ill_q;
  assign bytes_o   = bytes_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic             v_q;
    logic [1:0]       l_q;
    logic [INS_W-1:0] i_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        l_q <= '0;
        i_q <= '0;
      end else if (adv_i) begin
        v_q <= done_i & vld_i[s];
        l_q <= (done_i & vld_i[s]) ? len_i[s] : '0;
        i_q <= (done_i & vld_i[s]) ? ins_i[s] : '0;
      end
    end
    assign vld_o[s] = v_q;
    assign len_o[s] = l_q;
    assign ins_o[s] = i_q;

    AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !v_q |-> (i_q == '0 && l_q == '0)); // R8
  end

  AST_FLAG_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vld_q && ill_q)); // R3
  AST_BYTES_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (bytes_q >= BYTE_W'(2) && bytes_q <= BYTE_W'(2 * PKT_HW))); // R4
endmodule

// File: rtl/vliw_pkt_splitter.sv
module vliw_pkt_splitter import pks_pkg::*; #(
  parameter int HW_W   = 16,
  parameter int PKT_HW = 8,
  parameter int NSLOT  = 8,
  parameter int INS_HW = 3,
  localparam int WORD_W = HW_W * PKT_HW,
  localparam int INS_W  = INS_HW * HW_W,
  localparam int BUF_HW = 2 * PKT_HW,
  localparam int CNT_W  = $clog2(BUF_HW + 1),
  localparam int BYTE_W = $clog2(2 * PKT_HW + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetch_valid,
  input  logic [WORD_W-1:0]      fetch_word,
  output logic                   fetch_ready,
  input  logic                   out_ready,
  output logic                   pkt_valid,
  output logic                   pkt_illegal,
  output logic [BYTE_W-1:0]      pkt_bytes,
  output logic [NSLOT-1:0]       slot_valid,
  output logic [2*NSLOT-1:0]     slot_len,
  output logic [NSLOT*INS_W-1:0] slot_insn
);
  logic [PKT_HW-1:0][HW_W-1:0] word_hw;
  logic [BUF_HW-1:0][HW_W-1:0] buf_hw;
  logic [CNT_W-1:0]            buf_cnt, parse_used, pop_cnt;
  logic                        fetch_take, parse_done, parse_bad;
  logic [NSLOT-1:0]            parse_vld;
  logic [NSLOT-1:0][1:0]       parse_len, iss_len;
  logic [NSLOT-1:0][INS_W-1:0] parse_ins, iss_ins;

  assign word_hw    = fetch_word;
  assign fetch_take = fetch_valid & fetch_ready;
  assign pop_cnt    = out_ready ? parse_used : '0;

  pks_carry_buf #(.HW_W(HW_W), .PKT_HW(PKT_HW), .BUF_HW(BUF_HW), .CNT_W(CNT_W)) u_buf (
    .clk_i(clk), .rst_ni(rst_n), .push_i(fetch_take), .word_i(word_hw),
    .pop_i(pop_cnt), .hw_o(buf_hw), .cnt_o(buf_cnt), .room_o(fetch_ready)
  );

  pks_parse #(.HW_W(HW_W), .PKT_HW(PKT_HW), .NSLOT(NSLOT), .INS_HW(INS_HW),
              .BUF_HW(BUF_HW), .CNT_W(CNT_W)) u_parse (
    .hw_i(buf_hw), .cnt_i(buf_cnt), .done_o(parse_done), .bad_o(parse_bad),
    .used_o(parse_used), .vld_o(parse_vld), .len_o(parse_len), .ins_o(parse_ins)
  );

  pks_issue_reg #(.HW_W(HW_W), .PKT_HW(PKT_HW), .NSLOT(NSLOT), .INS_HW(INS_HW),
                  .CNT_W(CNT_W)) u_issue (
    .clk_i(clk), .rst_ni(rst_n), .adv_i(out_ready), .done_i(parse_done),
    .bad_i(parse_bad), .used_i(parse_used), .vld_i(parse_vld), .len_i(parse_len),
    .ins_i(parse_ins), .pkt_vld_o(pkt_valid), .pkt_ill_o(pkt_illegal),
    .bytes_o(pkt_bytes), .vld_o(slot_valid), .len_o(iss_len), .ins_o(iss_ins)
  );

  assign slot_len  = iss_len;
  assign slot_insn = iss_ins;

  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |=> ($stable(pkt_valid) && $stable(pkt_illegal) && $stable(slot_insn))); // R7
  AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((slot_valid + 1'b1) & slot_valid) == '0); // R2
  AST_PARSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(parse_done && parse_bad)); // R3
endmodule

// File: tb/tb_vliw_pkt_splitter.sv
module tb_vliw_pkt_splitter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         fetch_valid = 1'b0;
  logic [127:0] fetch_word = '0;
  logic         fetch_ready;
  logic         out_ready = 1'b0;
  logic         pkt_valid, pkt_illegal;
  logic [4:0]   pkt_bytes;
  logic [7:0]   slot_valid;
  logic [15:0]  slot_len;
  logic [383:0] slot_insn;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  vliw_pkt_splitter dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_word(fetch_word),
    .fetch_ready(fetch_ready), .out_ready(out_ready), .pkt_valid(pkt_valid),
    .pkt_illegal(pkt_illegal), .pkt_bytes(pkt_bytes), .slot_valid(slot_valid),
    .slot_len(slot_len), .slot_insn(slot_insn)
  );

  // {expected bytes, instruction count, length codes (slot s at bits 2s+1:2s)}
  localparam int NPKT = 13;
  localparam logic [24:0] PKT_TAB [NPKT] = '{
    {5'd2,  4'd1, 16'h0000},  // one 16-bit
    {5'd6,  4'd1, 16'h0002},  // one 48-bit
    {5'd16, 4'd8, 16'h0000},  // eight 16-bit
    {5'd14, 4'd4, 16'h0009},  // 32,48,16,16
    {5'd12, 4'd2, 16'h000A},  // 48,48
    {5'd16, 4'd4, 16'h0055},  // 32 x4
    {5'd16, 4'd5, 16'h0018},  // 16,48,32,16,16
    {5'd12, 4'd3, 16'h0006},  // 48,32,16
    {5'd6,  4'd3, 16'h0000},  // 16 x3
    {5'd4,  4'd1, 16'h0001},  // one 32-bit
    {5'd16, 4'd3, 16'h001A},  // 48,48,32
    {5'd14, 4'd5, 16'h0044},  // 16,32,16,32,16
    {5'd16, 4'd6, 16'h0800}   // 16 x5, 48
  };

  logic [15:0]  strm [0:127];
  logic [383:0] e_ins [0:31];
  logic [15:0]  e_len [0:31];
  logic [7:0]   e_vld [0:31];
  logic [4:0]   e_byt [0:31];
  int nhw, npk;

  logic         rdy_prev;
  logic [399:0] held;
  int got;

  function automatic logic [15:0] mk(input logic [1:0] c, input logic e, input logic [12:0] tag);
    return {tag, e, c};
  endfunction

  task automatic chk(input string what, input logic [399:0] act, input logic [399:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic build();
    logic [24:0] ent;
    int cnt, n;
    logic [1:0] c;
    logic [15:0] h;
    nhw = 0;
    npk = 0;
    for (int p = 0; p < NPKT + 5; p++) begin
      ent = (p < NPKT) ? PKT_TAB[p] : {5'd2, 4'd1, 16'h0000};
      cnt = int'(ent[19:16]);
      e_byt[npk] = ent[24:20];
      e_ins[npk] = '0;
      e_len[npk] = '0;
      e_vld[npk] = '0;
      for (int s = 0; s < cnt; s++) begin
        c = ent[2*s +: 2];
        n = int'(c) + 1;
        h = mk(c, (s == cnt - 1), 13'(nhw * 37 + 5));
        strm[nhw] = h;
        e_ins[npk][s*48 +: 16] = h;
        for (int k = 1; k < n; k++) begin
          h = 16'(nhw * 4951 + k * 13 + 9);
          strm[nhw + k] = h;
          e_ins[npk][s*48 + k*16 +: 16] = h;
        end
        e_vld[npk][s] = 1'b1;
        e_len[npk][2*s +: 2] = 2'(n);
        nhw = nhw + n;
      end
      npk++;
    end
  endtask

  task automatic push_word(input logic [127:0] w);
    logic acc;
    fetch_valid = 1'b1;
    fetch_word  = w;
    do begin
      acc = fetch_ready;
      @(negedge clk);
    end while (!acc);
    fetch_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] w1, w2;
    logic [383:0] ex;
    build();
    do_reset();
    @(negedge clk);
    // R9: state after reset
    chk("R9 reset outputs", 400'({fetch_ready, pkt_valid, pkt_illegal, pkt_bytes, slot_valid, slot_len}),
        400'({1'b1, 1'b0, 1'b0, 5'd0, 8'd0, 16'd0}));
    chk("R9 reset insn", 400'(slot_insn), 400'(0));

    // Table stream: packets end to end across words, ready taken away every fifth cycle
    rdy_prev = 1'b0;
    held = {16'd0, pkt_valid, pkt_illegal, pkt_bytes, slot_valid, slot_len, slot_insn} ;
    got = 0;
    fork
      begin
        for (int w = 0; w < nhw / 8; w++) begin
          logic [127:0] wd;
          for (int j = 0; j < 8; j++) wd[j*16 +: 16] = strm[w*8 + j];
          push_word(wd);
        end
      end
      begin
        for (int cyc = 1; cyc < 3000 && got < npk; cyc++) begin
          @(negedge clk);
          if (rdy_prev) begin
            if (pkt_valid || pkt_illegal) begin
              // R1 R2 R5 R8: flags, byte count, slot valid and lengths
              chk($sformatf("R1 R2 R5 R8 packet %0d header", got),
                  400'({pkt_valid, pkt_illegal, pkt_bytes, slot_valid, slot_len}),
                  400'({1'b1, 1'b0, e_byt[got], e_vld[got], e_len[got]}));
              chk($sformatf("R1 R2 R8 packet %0d slots", got), 400'(slot_insn), 400'(e_ins[got]));
              got++;
            end
          end else begin
            // R7: outputs unchanged across an edge without ready
            chk("R7 hold while not ready",
                400'({16'd0, pkt_valid, pkt_illegal, pkt_bytes, slot_valid, slot_len, slot_insn}), held);
          end
          held = {16'd0, pkt_valid, pkt_illegal, pkt_bytes, slot_valid, slot_len, slot_insn};
          out_ready = (cyc % 5 != 3);
          rdy_prev = out_ready;
        end
        chk("R5 all table packets issued", 400'(got), 400'(npk));
      end
    join

    // R3: reserved code, whole buffer dropped
    out_ready = 1'b1;
    do_reset();
    w1 = '0;
    w1[15:0] = mk(2'b11, 1'b1, 13'h11);
    for (int j = 1; j < 8; j++) w1[j*16 +: 16] = mk(2'b00, 1'b1, 13'(j));
    push_word(w1);
    @(negedge clk);
    chk("R3 reserved code flags", 400'({pkt_valid, pkt_illegal, pkt_bytes, slot_valid}),
        400'({1'b0, 1'b1, 5'd0, 8'd0}));
    chk("R3 R8 reserved code slots zero", 400'({slot_len, slot_insn}), 400'(0));
    @(negedge clk);
    chk("R3 rest of buffer discarded", 400'({pkt_valid, pkt_illegal}), 400'(0));

    // R4: eight 16-bit instructions and no end flag
    do_reset();
    for (int j = 0; j < 8; j++) w1[j*16 +: 16] = mk(2'b00, 1'b0, 13'(j + 40));
    push_word(w1);
    @(negedge clk);
    chk("R4 no end within 128 bits", 400'({pkt_valid, pkt_illegal, slot_valid}), 400'({1'b0, 1'b1, 8'd0}));

    // R4: 32-bit instruction starting at halfword 7 crosses the limit
    do_reset();
    for (int j = 0; j < 7; j++) w1[j*16 +: 16] = mk(2'b00, 1'b0, 13'(j + 60));
    w1[127:112] = mk(2'b01, 1'b1, 13'h77);
    push_word(w1);
    @(negedge clk);
    chk("R4 instruction crosses 128 bits", 400'({pkt_valid, pkt_illegal, slot_valid}), 400'({1'b0, 1'b1, 8'd0}));

    // R5 R10: packet spanning two fetch words
    do_reset();
    w1[15:0] = mk(2'b00, 1'b1, 13'h101);
    for (int j = 1; j < 6; j++) w1[j*16 +: 16] = mk(2'b00, 1'b0, 13'(j + 200));
    w1[111:96]  = mk(2'b10, 1'b1, 13'h1AB);
    w1[127:112] = 16'hBEEF;
    w2[15:0] = 16'hCAFE;
    for (int j = 1; j < 8; j++) w2[j*16 +: 16] = mk(2'b00, 1'b1, 13'(j + 300));
    push_word(w1);
    @(negedge clk);
    chk("R10 first packet one edge after fetch", 400'({pkt_valid, pkt_bytes, slot_valid, slot_insn[15:0]}),
        400'({1'b1, 5'd2, 8'h01, w1[15:0]}));
    @(negedge clk);
    chk("R5 incomplete packet waits", 400'({pkt_valid, pkt_illegal}), 400'(0));
    push_word(w2);
    @(negedge clk);
    ex = '0;
    for (int s = 0; s < 5; s++) ex[s*48 +: 16] = w1[(s+1)*16 +: 16];
    ex[5*48 +: 48] = {16'hCAFE, 16'hBEEF, w1[111:96]};
    chk("R5 R10 spanning packet header", 400'({pkt_valid, pkt_bytes, slot_valid, slot_len}),
        400'({1'b1, 5'd16, 8'h3F, 16'h0D55}));
    chk("R5 R1 spanning packet slots", 400'(slot_insn), 400'(ex));

    // R6 R7: back-pressure fills the buffer
    out_ready = 1'b0;
    do_reset();
    for (int j = 0; j < 8; j++) w1[j*16 +: 16] = mk(2'b00, 1'b1, 13'(j + 500));
    for (int j = 0; j < 8; j++) w2[j*16 +: 16] = mk(2'b00, 1'b1, 13'(j + 600));
    push_word(w1);
    chk("R6 ready with eight halfwords held", 400'(fetch_ready), 400'(1));
    push_word(w2);
    chk("R6 not ready with sixteen held", 400'(fetch_ready), 400'(0));
    chk("R7 nothing issued while not ready", 400'({pkt_valid, pkt_illegal, slot_valid}), 400'(0));
    out_ready = 1'b1;
    @(negedge clk);
    chk("R10 oldest packet issues once ready", 400'({pkt_valid, pkt_bytes, slot_valid, slot_insn}),
        400'({1'b1, 5'd2, 8'h01, 368'd0, w1[15:0]}));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule